// File: doc/BRIEF.md
# Five-Port Mesh Router for Single-Flit Packets

This block is the switching element placed at every node of a two-dimensional mesh. It has four neighbour ports (north, south, east, west) and one port for the attached core. Every packet is a single flit that carries its destination X and Y coordinates next to the payload. So an output is never reserved past the cycle that carries a flit, and flits from different inputs interleave freely on any output.

Each input has a small FIFO. The flit at the head of each FIFO is routed combinationally. The router compares the destination with its own coordinates, which are parameters, and corrects X completely before it moves in Y. Each output has its own round-robin arbiter, so several outputs can grant in one cycle. No register sits between the FIFO head and the output link, so a flit moves one hop per cycle. All ports use valid/ready handshakes.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Each input FIFO accepts a flit on a cycle where `in_valid` and `in_ready` are both 1. It holds up to DEPTH flits, drops `in_ready` when full, and delivers its flits in arrival order with none lost.
- R3: A flit accepted at a clock edge into an empty FIFO appears on its output in the next cycle, provided no other input competes for that output.
- R4: Port index order is local=0, north=1, south=2, east=3, west=4. Flit layout from the MSB down is destination Y (YW bits), destination X (XW bits), then payload (DW bits). Routing works as follows: if the destination X is above the router's own X the flit goes east, if below it goes west; with X equal, a destination Y above the router's own Y goes north and one below goes south; a destination equal to the router's own coordinates goes to the local port.
- R5: A head flit leaves its FIFO only on a cycle where it is granted and the chosen output's `out_ready` is 1. While `out_ready` is 0, the output keeps offering the flit and the input stays full.
- R6: Each output's round-robin pointer moves to the input just after the winner, and only on a cycle where that output's transfer completes. The input at the pointer has the highest priority, and priority falls in rising index order from there, wrapping around.
- R7: Different outputs can each complete a transfer in the same cycle.
- R8: Neighbours send only dimension-order traffic (the west input carries destination X at or above the router's own X, the east input X at or below it, the north and south inputs carry X equal to the router's own). Under that traffic, no flit leaves through the port it entered by, and no flit that arrived from north or south leaves east or west.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per-input flit valid |
| in_ready | output | 5 | Per-input FIFO has space |
| in_flit | input | 5 x (YW+XW+DW) | Per-input flit |
| out_valid | output | 5 | Per-output flit valid |
| out_ready | input | 5 | Per-output downstream can take a flit |
| out_flit | output | 5 x (YW+XW+DW) | Per-output flit |

## Verification
Several properties are checked on every cycle: the grants are one-hot, no input is dequeued while its output is stalled, and the pointer holds when no transfer completes and steps past the winner when one does. The same checks confirm that every offered flit's destination agrees with the direction of its output, and that U-turns and turns from Y back to X never happen. Other behaviours can only be shown by the bench scenarios, because they depend on a sequence of stimulus. These are the exact count of DEPTH accepted flits before backpressure, the one-cycle hop, the rotating grant order 3,4,0,1,2 after a win by input 2, two outputs transferring in the same cycle, and in-order, loss-free delivery checked against the scoreboard.

// File: rtl/mesh_rtr_pkg.sv
`timescale 1ns/1ps
package mesh_rtr_pkg;
   localparam int NPORT = 5;
   localparam int P_LOC = 0;
   localparam int P_N   = 1;
   localparam int P_S   = 2;
   localparam int P_E   = 3;
   localparam int P_W   = 4;
endpackage

// File: rtl/mesh_rtr_fifo.sv
`timescale 1ns/1ps
module mesh_rtr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         nonempty,
   output logic         space
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH == 1) begin : g_single
         logic         held;
         logic [W-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= 1'b0;
            else if (push) held <= 1'b1;
            else if (pop) held <= 1'b0;
         end
         always_ff @(posedge clk) begin
            if (push) slot <= din;
         end
         assign dout     = slot;
         assign nonempty = held;
         assign space    = !held;
      end else begin : g_ring
         logic [W-1:0] mem [DEPTH];
         logic [AW:0]  wp;
         logic [AW:0]  rp;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (push) wp <= wp + 1'b1;
               if (pop)  rp <= rp + 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wp[AW-1:0]] <= din;
         end
         assign dout     = mem[rp[AW-1:0]];
         assign nonempty = (wp != rp);
         assign space    = !((wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]));
      end
   endgenerate
endmodule

// File: rtl/mesh_rtr_route.sv
`timescale 1ns/1ps
module mesh_rtr_route
   import mesh_rtr_pkg::*;
#(
   parameter int XW   = 5,
   parameter int YW   = 5,
   parameter int MY_X = 0,
   parameter int MY_Y = 0
) (
   input  logic [XW-1:0]    dst_x,
   input  logic [YW-1:0]    dst_y,
   output logic [NPORT-1:0] dir
);
   localparam logic [XW-1:0] OWN_X = XW'(MY_X);
   localparam logic [YW-1:0] OWN_Y = YW'(MY_Y);

   // X is corrected fully before any Y movement
   always_comb begin
      dir = '0;
      if (dst_x > OWN_X)      dir[P_E]   = 1'b1;
      else if (dst_x < OWN_X) dir[P_W]   = 1'b1;
      else if (dst_y > OWN_Y) dir[P_N]   = 1'b1;
      else if (dst_y < OWN_Y) dir[P_S]   = 1'b1;
      else                    dir[P_LOC] = 1'b1;
   end
endmodule

// File: rtl/mesh_rtr_arb.sv
`timescale 1ns/1ps
module mesh_rtr_arb #(
   parameter int N = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic                 accept,
   output logic [N-1:0]         gnt,
   output logic [$clog2(N)-1:0] ptr
);
   localparam int PW = $clog2(N);

   logic [PW-1:0] win;
   logic [PW-1:0] nxt;

   always_comb begin
      logic found;
      gnt   = '0;
      win   = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            gnt[idx] = 1'b1;
            win      = PW'(idx);
            found    = 1'b1;
         end
      end
   end

   assign nxt = (win == PW'(N - 1)) ? '0 : win + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else if (accept) ptr <= nxt;
   end
endmodule

// File: rtl/mesh_router.sv
`timescale 1ns/1ps
module mesh_router
   import mesh_rtr_pkg::*;
#(
   parameter int XW    = 5,
   parameter int YW    = 5,
   parameter int DW    = 32,
   parameter int DEPTH = 2,
   parameter int MY_X  = 0,
   parameter int MY_Y  = 0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NPORT-1:0]                 in_valid,
   output logic [NPORT-1:0]                 in_ready,
   input  logic [NPORT-1:0][YW+XW+DW-1:0]   in_flit,
   output logic [NPORT-1:0]                 out_valid,
   input  logic [NPORT-1:0]                 out_ready,
   output logic [NPORT-1:0][YW+XW+DW-1:0]   out_flit
);
   localparam int FW = YW + XW + DW;
   localparam int PW = $clog2(NPORT);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mesh_router: DEPTH must be a power of two");
      end
      if (MY_X < 0 || MY_X >= (1 << XW) || MY_Y < 0 || MY_Y >= (1 << YW)) begin : g_bad_xy
         $error("mesh_router: own coordinates do not fit the address fields");
      end
      if (DW < 1) begin : g_bad_dw
         $error("mesh_router: DW must be at least 1");
      end
   endgenerate

   logic [NPORT-1:0]              head_v;
   logic [NPORT-1:0][FW-1:0]      head_f;
   logic [NPORT-1:0][NPORT-1:0]   dir;      // [input][output]
   logic [NPORT-1:0][NPORT-1:0]   req;      // [output][input]
   logic [NPORT-1:0][NPORT-1:0]   gnt;      // [output][input]
   logic [NPORT-1:0]              pop;
   logic [NPORT-1:0][PW-1:0]      rr_ptr;

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_in
         mesh_rtr_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (in_valid[i] && in_ready[i]),
            .din      (in_flit[i]),
            .pop      (pop[i]),
            .dout     (head_f[i]),
            .nonempty (head_v[i]),
            .space    (in_ready[i])
         );
         mesh_rtr_route #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .dst_x (head_f[i][DW +: XW]),
            .dst_y (head_f[i][DW+XW +: YW]),
            .dir   (dir[i])
         );
      end

      for (genvar o = 0; o < NPORT; o++) begin : g_out
         for (genvar i = 0; i < NPORT; i++) begin : g_req
            assign req[o][i] = head_v[i] && dir[i][o];
         end
         assign out_valid[o] = |req[o];

         mesh_rtr_arb #(.N(NPORT)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req[o]),
            .accept (out_valid[o] && out_ready[o]),
            .gnt    (gnt[o]),
            .ptr    (rr_ptr[o])
         );

         always_comb begin
            out_flit[o] = '0;
            for (int i = 0; i < NPORT; i++) begin
               if (gnt[o][i]) out_flit[o] = out_flit[o] | head_f[i];
            end
         end
      end
   endgenerate

   // dequeue only on a granted, accepted transfer
   always_comb begin
      pop = '0;
      for (int o = 0; o < NPORT; o++) begin
         for (int i = 0; i < NPORT; i++) begin
            if (gnt[o][i] && out_ready[o]) pop[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mesh_router_chk.sv
`timescale 1ns/1ps
module mesh_router_chk
   import mesh_rtr_pkg::*;
#(
   parameter int XW   = 5,
   parameter int YW   = 5,
   parameter int DW   = 32,
   parameter int MY_X = 0,
   parameter int MY_Y = 0
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NPORT-1:0]                  in_valid,
   input logic [NPORT-1:0]                  in_ready,
   input logic [NPORT-1:0]                  out_valid,
   input logic [NPORT-1:0]                  out_ready,
   input logic [NPORT-1:0][YW+XW+DW-1:0]    out_flit,
   input logic [NPORT-1:0][NPORT-1:0]       gnt,
   input logic [NPORT-1:0]                  pop,
   input logic [NPORT-1:0][$clog2(NPORT)-1:0] rr_ptr
);
   localparam int PW = $clog2(NPORT);
   localparam logic [XW-1:0] OX = XW'(MY_X);
   localparam logic [YW-1:0] OY = YW'(MY_Y);

   function automatic logic dir_ok(int o, logic [XW-1:0] dx, logic [YW-1:0] dy);
      case (o)
         P_E:     return dx > OX;
         P_W:     return dx < OX;
         P_N:     return (dx == OX) && (dy > OY);
         P_S:     return (dx == OX) && (dy < OY);
         default: return (dx == OX) && (dy == OY);
      endcase
   endfunction

   logic [NPORT-1:0][PW-1:0] exp_nxt;
   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         exp_nxt[o] = '0;
         for (int i = 0; i < NPORT; i++) begin
            if (gnt[o][i]) exp_nxt[o] = (i == NPORT - 1) ? '0 : PW'(i + 1);
         end
      end
   end

   generate
      for (genvar o = 0; o < NPORT; o++) begin : g_o
         a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[o]) && (out_valid[o] == (gnt[o] != '0)));

         a_r4_dir_match: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> dir_ok(o, out_flit[o][DW +: XW], out_flit[o][DW+XW +: YW]));

         a_r5_stall_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |-> ((pop & gnt[o]) == '0));

         a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_valid[o] && out_ready[o]) |=> $stable(rr_ptr[o]));

         a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && out_ready[o]) |=> (rr_ptr[o] == $past(exp_nxt[o])));
      end

      for (genvar i = 0; i < NPORT; i++) begin : g_i
         a_r2_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_ready[i] && !pop[i]) |=> !in_ready[i]);

         a_r3_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && in_ready[i]) |=> (out_valid != '0));

         if (i != P_LOC) begin : g_card
            a_r8_no_uturn: assert property (@(posedge clk) disable iff (!rst_n)
               !gnt[i][i]);
         end
      end
   endgenerate

   a_r8_no_y_to_x: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt[P_E][P_N] || gnt[P_E][P_S] || gnt[P_W][P_N] || gnt[P_W][P_S]));
endmodule

bind mesh_router mesh_router_chk #(
   .XW(XW), .YW(YW), .DW(DW), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_flit  (out_flit),
   .gnt       (gnt),
   .pop       (pop),
   .rr_ptr    (rr_ptr)
);

// File: tb/sim_mesh_router.sv
`timescale 1ns/1ps
module sim_mesh_router;
   localparam int NP    = 5;
   localparam int XW    = 5;
   localparam int YW    = 5;
   localparam int DW    = 16;
   localparam int DEPTH = 4;
   localparam int MX    = 2;
   localparam int MY    = 2;
   localparam int FW    = YW + XW + DW;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NP-1:0]          in_valid = '0;
   logic [NP-1:0]          in_ready;
   logic [NP-1:0][FW-1:0]  in_flit = '0;
   logic [NP-1:0]          out_valid;
   logic [NP-1:0]          out_ready = '0;
   logic [NP-1:0][FW-1:0]  out_flit;

   int total = 0;
   int bad   = 0;
   int seq   = 0;
   bit done  = 1'b0;

   logic [FW-1:0] sb [NP][NP][$];
   bit rr_en = 1'b0;
   int rr_log[$];

   always #10 clk = ~clk;

   mesh_router #(.XW(XW), .YW(YW), .DW(DW), .DEPTH(DEPTH), .MY_X(MX), .MY_Y(MY)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
      .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // R4 direction model: local=0 north=1 south=2 east=3 west=4
   function automatic int exp_dir(int dx, int dy);
      if (dx > MX) return 3;
      if (dx < MX) return 4;
      if (dy > MY) return 1;
      if (dy < MY) return 2;
      return 0;
   endfunction

   function automatic logic [FW-1:0] mk(int dx, int dy, int src, int s);
      return {YW'(dy), XW'(dx), 3'(src), 13'(s)};
   endfunction

   // driver: called at a negedge, returns at the negedge after acceptance
   task automatic send(input int p, input int dx, input int dy);
      logic [FW-1:0] f;
      bit r;
      f = mk(dx, dy, p, seq);
      seq++;
      sb[exp_dir(dx, dy)][p].push_back(f);
      in_valid[p] = 1'b1;
      in_flit[p]  = f;
      forever begin
         r = in_ready[p];
         @(negedge clk);
         if (r) break;
      end
      in_valid[p] = 1'b0;
   endtask

   // monitor: samples shortly before each rising edge
   always begin
      @(negedge clk);
      #8;
      if (rst_n) begin
         for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && out_ready[o]) begin
               int src;
               src = int'(out_flit[o][DW-1 -: 3]);
               if (rr_en && o == 0) rr_log.push_back(src);
               if (src >= NP || sb[o][src].size() == 0) begin
                  chk(1'b0, "R4 unexpected flit on output", longint'(out_flit[o]), o);
               end else begin
                  logic [FW-1:0] e;
                  e = sb[o][src].pop_front();
                  chk(out_flit[o] == e, "R2 R4 scoreboard order/route", longint'(out_flit[o]), longint'(e));
               end
            end
         end
      end
   end

   function automatic int sb_left();
      int n = 0;
      for (int o = 0; o < NP; o++)
         for (int i = 0; i < NP; i++) n += sb[o][i].size();
      return n;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [FW-1:0] first;
      int n;
      bit r;
      idle(3);
      chk(out_valid == '0, "R1 out_valid in reset", out_valid, 0);
      chk(in_ready == 5'h1f, "R1 in_ready in reset", in_ready, 5'h1f);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
      chk(in_ready == 5'h1f, "R1 in_ready after reset", in_ready, 5'h1f);

      // R4 routing from the local input to every direction
      out_ready = '1;
      send(0, 2, 2);
      send(0, 4, 1);
      send(0, 0, 3);
      send(0, 2, 4);
      send(0, 2, 0);
      idle(3);
      chk(sb_left() == 0, "R4 all local-sourced flits routed", sb_left(), 0);

      // R3 one-cycle hop
      chk(out_valid[3] == 1'b0, "R3 east idle before", out_valid[3], 0);
      send(0, 3, 2);
      chk(out_valid[3] == 1'b1, "R3 east valid one cycle after accept", out_valid[3], 1);
      idle(2);

      // R2 / R5 backpressure
      out_ready[3] = 1'b0;
      n = 0;
      in_valid[0] = 1'b1;
      repeat (DEPTH + 2) begin
         in_flit[0] = mk(4, 2, 0, seq);
         r = in_ready[0];
         if (r) begin
            if (n == 0) first = in_flit[0];
            sb[3][0].push_back(in_flit[0]);
            seq++;
            n++;
         end
         @(negedge clk);
      end
      in_valid[0] = 1'b0;
      chk(n == DEPTH, "R2 accepted count equals DEPTH", n, DEPTH);
      chk(in_ready[0] == 1'b0, "R2 in_ready low when full", in_ready[0], 0);
      idle(5);
      chk(out_valid[3] == 1'b1, "R5 stalled output keeps valid", out_valid[3], 1);
      chk(out_flit[3] == first, "R5 stalled output holds head flit", out_flit[3], first);
      chk(in_ready[0] == 1'b0, "R5 no dequeue while stalled", in_ready[0], 0);
      out_ready[3] = 1'b1;
      idle(DEPTH + 3);
      chk(sb_left() == 0, "R2 backlog drained in order", sb_left(), 0);
      chk(in_ready[0] == 1'b1, "R2 space after drain", in_ready[0], 1);

      // R6 round-robin: win by input 2 moves pointer to 3
      send(2, 2, 2);
      idle(2);
      out_ready[0] = 1'b0;
      send(0, 2, 2);
      send(1, 2, 2);
      send(2, 2, 2);
      send(3, 2, 2);
      send(4, 2, 2);
      rr_log.delete();
      rr_en = 1'b1;
      out_ready[0] = 1'b1;
      idle(8);
      rr_en = 1'b0;
      chk(rr_log.size() == 5, "R6 five grants on local output", rr_log.size(), 5);
      if (rr_log.size() == 5) begin
         int exp_ord[5] = '{3, 4, 0, 1, 2};
         for (int k = 0; k < 5; k++)
            chk(rr_log[k] == exp_ord[k], "R6 grant order", rr_log[k], exp_ord[k]);
      end

      // R7 two outputs in one cycle
      fork
         send(0, 4, 2);
         send(1, 2, 0);
      join
      chk(out_valid[3] && out_valid[2], "R7 east and south valid together",
          {out_valid[3], out_valid[2]}, 2'b11);
      idle(3);

      // R8 transit traffic from neighbours
      send(4, 4, 2);
      send(4, 2, 4);
      send(1, 2, 0);
      chk(out_valid[1] == 1'b0 && out_valid[3] == 1'b0 && out_valid[4] == 1'b0,
          "R8 north-in flit only on south", {out_valid[1], out_valid[3], out_valid[4]}, 0);
      send(2, 2, 4);
      send(3, 0, 2);
      send(1, 2, 2);
      idle(4);
      chk(sb_left() == 0, "R8 transit flits delivered", sb_left(), 0);

      idle(2);
      chk(sb_left() == 0, "R2 nothing lost at end", sb_left(), 0);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule